// File: doc/BRIEF.md
# Receive Descriptor Completion Writer

This block closes out received frames by updating a ring of receive descriptors kept in a small local memory. Each descriptor is four 32-bit words: a status word at offset 0, a control word at offset 1 (buffer size in bits 10:0), a buffer address at offset 2 (never touched here), and a next-descriptor index at offset 3. When the receive path signals that a frame is done, the block reads the current descriptor. It checks that the hardware owns it, then writes back a status word. That word holds the frame length, the address-match class, the first and last marks and the error flags, with the ownership bit cleared. The block then follows the stored next index to the following entry.

A frame longer than the current buffer spills over into further owned descriptors. Only the descriptor that holds the end of the frame carries the final length and the last mark. If the block finds a descriptor that software has not handed back, it drops the rest of the frame and raises a buffer-unavailable flag. While that flag is up, the block stays suspended and ignores new frames. A poll-demand strobe from software resumes it.

The descriptor memory sits outside the block. Reads use a one-cycle latency port and writes use a separate port, so the memory can be a plain synchronous RAM shared with the software side.

Top module: `rx_desc_writer`

## Requirements
- R1: When a frame completes, the block reads the status word of the current descriptor. If its bit 31 is clear, the block writes nothing for that frame, drops it and sets `no_buf`.
- R2: Each descriptor write targets only the status word (word offset 0 of the entry) and leaves bit 31 clear. The read and write ports are never active in the same cycle.
- R3: The descriptor that receives the end of a frame has the full frame length, as given on `frm_len` (including CRC), in status bits 27:16.
- R4: On that descriptor, `frm_match` code 1 (own station) sets bit 12, code 2 (broadcast) sets bit 13 and code 3 (multicast) sets bit 14. Code 0 sets none of them.
- R5: Bit 11 is set on the first descriptor of a frame and bit 10 on the last. A frame whose length is at most the buffer size sets both bits in one descriptor.
- R6: `frm_err` bits 4..0 (runt, long, alignment, CRC, receive error) appear in status bits 6..2 of the last descriptor. Bit 7 is set exactly when any of them is set.
- R7: The buffer size is taken from control word bits 10:0. After a descriptor is written, `ring_pos` becomes the index held in bits IDX_W-1:0 of that entry's word 3, so the ring order, including the wrap, follows the stored pointers.
- R8: A frame longer than the remaining buffer continues into the next descriptor, reduced by the buffer size. A non-final descriptor gets a status word with only bit 11 possibly set: zero length, no match, no error and no last bits.
- R9: `no_buf` stays set until a `poll_demand` pulse clears it. While it is set, `frm_done` pulses are dropped with no descriptor access and no change of `ring_pos`.
- R10: A `frm_done` pulse that arrives while `busy` is high is ignored.
- R11: After reset, `ring_pos` is 0, `no_buf` and `busy` are low and neither memory port is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frm_done | input | 1 | One-cycle pulse: a frame has been received |
| frm_len | input | LEN_W | Frame length in bytes including CRC |
| frm_match | input | 2 | Address match class: 0 none, 1 station, 2 broadcast, 3 multicast |
| frm_err | input | 5 | Error flags: 4 runt, 3 long, 2 alignment, 1 CRC, 0 receive error |
| poll_demand | input | 1 | One-cycle pulse that clears the buffer-unavailable state |
| busy | output | 1 | High while a frame is being written into the ring |
| ring_pos | output | IDX_W | Index of the current descriptor |
| no_buf | output | 1 | Receive buffer unavailable; the block is suspended |
| dsc_rd_en | output | 1 | Descriptor memory read enable |
| dsc_rd_addr | output | IDX_W+2 | Read word address {index, word offset} |
| dsc_rd_data | input | 32 | Read data, valid the cycle after the read enable |
| dsc_wr_en | output | 1 | Descriptor memory write enable |
| dsc_wr_addr | output | IDX_W+2 | Write word address {index, word offset} |
| dsc_wr_data | output | 32 | Status word to write |

## Verification
The assertions check on every cycle the properties of each write taken alone. Every write goes to a status word and hands ownership back. The error summary always agrees with the error bits, and at most one match bit is set. Intermediate descriptors are bare, the position follows the pointer just read, and a suspended block touches no memory. Only the bench's scenarios can show that the right descriptor got the right content. This covers how long frames are split across buffers of different sizes, the wrap through pointers that are not in sequential order, and dropping when a descriptor is not owned. It also covers the poll-driven resume and the frames ignored while busy. The bench checks all of these by comparing the whole descriptor memory with an independent ring model after each frame.

// File: rtl/rxdc_pkg.sv
package rxdc_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned OWN_POS     = 31;
  localparam int unsigned LEN_LSB     = 16;
  localparam int unsigned LEN_FIELD_W = 12;
  localparam int unsigned MC_POS      = 14;
  localparam int unsigned BC_POS      = 13;
  localparam int unsigned UC_POS      = 12;
  localparam int unsigned FIRST_POS   = 11;
  localparam int unsigned LAST_POS    = 10;
  localparam int unsigned ESUM_POS    = 7;
  localparam int unsigned ERR_LSB     = 2;
  localparam int unsigned ERR_W       = 5;

  // Word offsets inside one descriptor entry
  localparam logic [1:0] OFS_STAT = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_NEXT = 2'd3;

  typedef enum logic [1:0] {
    MATCH_NONE    = 2'd0,
    MATCH_STATION = 2'd1,
    MATCH_BCAST   = 2'd2,
    MATCH_MCAST   = 2'd3
  } match_e;

  typedef enum logic [2:0] {
    WS_IDLE   = 3'd0,
    WS_RSTAT  = 3'd1,
    WS_CHKOWN = 3'd2,
    WS_RNXT   = 3'd3,
    WS_WRITE  = 3'd4
  } walk_e;

endpackage

// File: rtl/rxdc_rst_sync.sv
module rxdc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rxdc_status_pack.sv
module rxdc_status_pack
  import rxdc_pkg::*;
#(
  parameter int unsigned LEN_W = 12
) (
  input  logic              first_i,
  input  logic              last_i,
  input  logic [LEN_W-1:0]  len_i,
  input  match_e            match_i,
  input  logic [ERR_W-1:0]  err_i,
  output logic [WORD_W-1:0] word_o
);

  // Place each error flag at its status position
  logic [WORD_W-1:0] err_placed;

  for (genvar g = 0; g < ERR_W; g++) begin : g_err
    assign err_placed[ERR_LSB+g] = err_i[g];
  end
  for (genvar h = 0; h < WORD_W; h++) begin : g_fill
    if (h < ERR_LSB || h >= ERR_LSB + ERR_W) begin : g_zero
      assign err_placed[h] = 1'b0;
    end
  end

  always_comb begin
    word_o            = '0;
    word_o[FIRST_POS] = first_i;
    if (last_i) begin
      word_o                    = word_o | err_placed;
      word_o[LAST_POS]          = 1'b1;
      word_o[LEN_LSB +: LEN_W]  = len_i;
      word_o[ESUM_POS]          = |err_i;
      unique case (match_i)
        MATCH_STATION: word_o[UC_POS] = 1'b1;
        MATCH_BCAST:   word_o[BC_POS] = 1'b1;
        MATCH_MCAST:   word_o[MC_POS] = 1'b1;
        default:       ;
      endcase
    end
  end

endmodule

// File: rtl/rxdc_nobuf_flag.sv
module rxdc_nobuf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_n, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_n  = set_i;          // a new drop wins over a poll in the same cycle
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_n;
    end
  end

  assign flag_o = flag_q;

  AST_NOBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_i |=> flag_q) else $error("no_buf dropped without poll"); // R9

  AST_NOBUF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q) else $error("drop did not raise no_buf"); // R1

endmodule

// File: rtl/rxdc_walker.sv
module rxdc_walker
  import rxdc_pkg::*;
#(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned LEN_W = 12,
  parameter int unsigned BSZ_W = 11,
  localparam int unsigned AW   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_done_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  input  match_e            frm_match_i,
  input  logic [ERR_W-1:0]  frm_err_i,
  input  logic              suspend_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              rd_en_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic              first_o,
  output logic              last_o,
  output logic [LEN_W-1:0]  len_o,
  output match_e            match_o,
  output logic [ERR_W-1:0]  err_o,
  output logic              drop_o,
  output logic              busy_o,
  output logic [IDX_W-1:0]  pos_o
);

  walk_e             state_q, state_n;
  logic [IDX_W-1:0]  pos_q, pos_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  match_e            match_q, match_n;
  logic [ERR_W-1:0]  err_q, err_n;
  logic              first_q, first_n;
  logic [BSZ_W-1:0]  bsz_q, bsz_n;
  logic              frame_en, pos_en, bsz_en, step_en;
  logic [LEN_W:0]    rem_x, bsz_x;
  logic              fits;
  logic              unused_rd_bits;

  assign unused_rd_bits = ^rd_data_i;

  always_comb begin
    rem_x = {1'b0, rem_q};
    bsz_x = '0;
    bsz_x[BSZ_W-1:0] = bsz_q;
    fits  = (rem_x <= bsz_x);
  end

  always_comb begin
    state_n   = state_q;
    pos_n     = pos_q;
    len_n     = len_q;
    rem_n     = rem_q;
    match_n   = match_q;
    err_n     = err_q;
    first_n   = first_q;
    bsz_n     = bsz_q;
    frame_en  = 1'b0;
    pos_en    = 1'b0;
    bsz_en    = 1'b0;
    step_en   = 1'b0;
    rd_en_o   = 1'b0;
    rd_addr_o = {pos_q, OFS_STAT};
    wr_en_o   = 1'b0;
    wr_addr_o = {pos_q, OFS_STAT};
    drop_o    = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (frm_done_i && !suspend_i) begin
          frame_en = 1'b1;
          len_n    = frm_len_i;
          rem_n    = frm_len_i;
          match_n  = frm_match_i;
          err_n    = frm_err_i;
          first_n  = 1'b1;
          state_n  = WS_RSTAT;
        end
      end
      WS_RSTAT: begin
        rd_en_o   = 1'b1;
        rd_addr_o = {pos_q, OFS_STAT};
        state_n   = WS_CHKOWN;
      end
      WS_CHKOWN: begin
        if (rd_data_i[OWN_POS]) begin
          rd_en_o   = 1'b1;
          rd_addr_o = {pos_q, OFS_CTRL};
          state_n   = WS_RNXT;
        end else begin
          drop_o  = 1'b1;
          state_n = WS_IDLE;
        end
      end
      WS_RNXT: begin
        bsz_en    = 1'b1;
        bsz_n     = rd_data_i[BSZ_W-1:0];
        rd_en_o   = 1'b1;
        rd_addr_o = {pos_q, OFS_NEXT};
        state_n   = WS_WRITE;
      end
      WS_WRITE: begin
        wr_en_o   = 1'b1;
        wr_addr_o = {pos_q, OFS_STAT};
        pos_en    = 1'b1;
        pos_n     = rd_data_i[IDX_W-1:0];
        if (fits) begin
          state_n = WS_IDLE;
        end else begin
          step_en = 1'b1;
          rem_n   = rem_q - bsz_x[LEN_W-1:0];
          first_n = 1'b0;
          state_n = WS_RSTAT;
        end
      end
      default: state_n = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      match_q <= MATCH_NONE;
      err_q   <= '0;
    end else if (frame_en) begin
      len_q   <= len_n;
      match_q <= match_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      first_q <= 1'b0;
    end else if (frame_en || step_en) begin
      rem_q   <= rem_n;
      first_q <= first_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsz_q <= '0;
    end else if (bsz_en) begin
      bsz_q <= bsz_n;
    end
  end

  assign first_o = first_q;
  assign last_o  = fits;
  assign len_o   = len_q;
  assign match_o = match_q;
  assign err_o   = err_q;
  assign busy_o  = (state_q != WS_IDLE);
  assign pos_o   = pos_q;

  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_o && wr_en_o)) else $error("read and write together"); // R2

  AST_FOLLOW_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (pos_q == $past(rd_data_i[IDX_W-1:0]))) else $error("ring position did not follow pointer"); // R7

  AST_WRITE_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_CHKOWN) && !rd_data_i[OWN_POS] |=> !wr_en_o) else $error("write after unowned status"); // R1

endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
  import rxdc_pkg::*;
#(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned LEN_W = 12,
  parameter int unsigned BSZ_W = 11,
  localparam int unsigned AW   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_done,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [1:0]        frm_match,
  input  logic [4:0]        frm_err,
  input  logic              poll_demand,
  output logic              busy,
  output logic [IDX_W-1:0]  ring_pos,
  output logic              no_buf,
  output logic              dsc_rd_en,
  output logic [AW-1:0]     dsc_rd_addr,
  input  logic [31:0]       dsc_rd_data,
  output logic              dsc_wr_en,
  output logic [AW-1:0]     dsc_wr_addr,
  output logic [31:0]       dsc_wr_data
);

  logic             rst_sync_n;
  logic             w_first, w_last, w_drop;
  logic [LEN_W-1:0] w_len;
  match_e           w_match;
  logic [ERR_W-1:0] w_err;

  rxdc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxdc_walker #(
    .IDX_W (IDX_W),
    .LEN_W (LEN_W),
    .BSZ_W (BSZ_W)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frm_done_i  (frm_done),
    .frm_len_i   (frm_len),
    .frm_match_i (match_e'(frm_match)),
    .frm_err_i   (frm_err),
    .suspend_i   (no_buf),
    .rd_data_i   (dsc_rd_data),
    .rd_en_o     (dsc_rd_en),
    .rd_addr_o   (dsc_rd_addr),
    .wr_en_o     (dsc_wr_en),
    .wr_addr_o   (dsc_wr_addr),
    .first_o     (w_first),
    .last_o      (w_last),
    .len_o       (w_len),
    .match_o     (w_match),
    .err_o       (w_err),
    .drop_o      (w_drop),
    .busy_o      (busy),
    .pos_o       (ring_pos)
  );

  rxdc_status_pack #(.LEN_W(LEN_W)) u_pack (
    .first_i (w_first),
    .last_i  (w_last),
    .len_i   (w_len),
    .match_i (w_match),
    .err_i   (w_err),
    .word_o  (dsc_wr_data)
  );

  rxdc_nobuf_flag u_nobuf (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (w_drop),
    .clr_i  (poll_demand),
    .flag_o (no_buf)
  );

  AST_OWN_RETURNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsc_wr_en |-> !dsc_wr_data[OWN_POS]) else $error("ownership not cleared"); // R2

  AST_STATUS_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsc_wr_en |-> (dsc_wr_addr[1:0] == OFS_STAT)) else $error("write outside status word"); // R2

  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsc_wr_en |-> (dsc_wr_data[ESUM_POS] == (|dsc_wr_data[ERR_LSB +: ERR_W]))) else $error("summary mismatch"); // R6

  AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsc_wr_en |-> $onehot0(dsc_wr_data[MC_POS:UC_POS])) else $error("several match bits"); // R4

  AST_MIDDLE_BARE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsc_wr_en && !dsc_wr_data[LAST_POS] |->
      (dsc_wr_data[LEN_LSB +: LEN_W] == '0) && (dsc_wr_data[MC_POS:UC_POS] == '0) &&
      (dsc_wr_data[ESUM_POS:0] == '0)) else $error("non-final descriptor carries frame data"); // R8

  AST_SUSPENDED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    no_buf |-> !dsc_rd_en && !dsc_wr_en) else $error("memory access while suspended"); // R9

endmodule

// File: tb/rx_desc_writer_bench.sv
`timescale 1ns/1ps
module rx_desc_writer_bench;

  localparam int IDXW  = 2;
  localparam int NDESC = 4;
  localparam int AWB   = IDXW + 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            frm_done, poll_demand;
  logic [11:0]     frm_len;
  logic [1:0]      frm_match;
  logic [4:0]      frm_err;
  logic            busy, no_buf, dsc_rd_en, dsc_wr_en;
  logic [IDXW-1:0] ring_pos;
  logic [AWB-1:0]  dsc_rd_addr, dsc_wr_addr;
  logic [31:0]     dsc_rd_data, dsc_wr_data;

  logic [31:0] dmem [0:4*NDESC-1];
  logic [31:0] em   [0:4*NDESC-1];
  int          exp_pos;
  bit          exp_nobuf;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;
  int unsigned seed_val;

  always #2.5 clk = ~clk;

  rx_desc_writer #(.IDX_W(IDXW), .LEN_W(12), .BSZ_W(11)) u_rx_desc_writer (
    .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_len(frm_len),
    .frm_match(frm_match), .frm_err(frm_err), .poll_demand(poll_demand),
    .busy(busy), .ring_pos(ring_pos), .no_buf(no_buf),
    .dsc_rd_en(dsc_rd_en), .dsc_rd_addr(dsc_rd_addr), .dsc_rd_data(dsc_rd_data),
    .dsc_wr_en(dsc_wr_en), .dsc_wr_addr(dsc_wr_addr), .dsc_wr_data(dsc_wr_data)
  );

  // Descriptor memory: one-cycle read latency
  always @(posedge clk) begin
    if (dsc_wr_en) dmem[dsc_wr_addr] <= dsc_wr_data;
    if (dsc_rd_en) dsc_rd_data <= dmem[dsc_rd_addr];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic arm(input int idx, input bit own, input int bsz, input int nxt);
    dmem[idx*4]   = {own, 31'd0};
    dmem[idx*4+1] = 32'(bsz);
    dmem[idx*4+2] = 32'h1000 + 32'(idx);
    dmem[idx*4+3] = 32'(nxt);
    for (int k = 0; k < 4; k++) em[idx*4+k] = dmem[idx*4+k];
  endtask

  // Reference ring model built from the requirements
  task automatic model_frame(input int len, input int m, input int e);
    int rem; bit first; bit fin; logic [31:0] w; int bsz; int nxt;
    if (!exp_nobuf) begin
      rem = len; first = 1'b1; fin = 1'b0;
      while (!fin) begin
        if (!em[exp_pos*4][31]) begin
          exp_nobuf = 1'b1; fin = 1'b1;                   // R1
        end else begin
          bsz = int'(em[exp_pos*4+1] & 32'h7ff);          // R7
          nxt = int'(em[exp_pos*4+3] & 32'(NDESC-1));
          w = '0; w[11] = first;                          // R5
          if (rem <= bsz) begin
            w[10] = 1'b1; w[27:16] = 12'(len);            // R3
            if (m == 1) w[12] = 1'b1;                     // R4
            if (m == 2) w[13] = 1'b1;
            if (m == 3) w[14] = 1'b1;
            w[6:2] = 5'(e); w[7] = |5'(e);                // R6
            fin = 1'b1;
          end else begin
            rem = rem - bsz; first = 1'b0;                // R8
          end
          em[exp_pos*4] = w;
          exp_pos = nxt;
        end
      end
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  task automatic send(input int len, input int m, input int e);
    @(negedge clk);
    frm_done = 1'b1; frm_len = 12'(len); frm_match = 2'(m); frm_err = 5'(e);
    @(negedge clk);
    frm_done = 1'b0;
    model_frame(len, m, e);
    wait_idle();
  endtask

  task automatic poll();
    @(negedge clk); poll_demand = 1'b1;
    @(negedge clk); poll_demand = 1'b0;
    exp_nobuf = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_ring(input string req);
    bit same = 1'b1; int bad = 0;
    for (int k = 0; k < 4*NDESC; k++) if (dmem[k] !== em[k]) begin same = 1'b0; bad = k; end
    check(same, {req, " descriptor memory"}, dmem[bad], em[bad]);
    check(ring_pos === IDXW'(exp_pos), {req, " ring_pos"}, 32'(ring_pos), 32'(exp_pos));
    check(no_buf === exp_nobuf, {req, " no_buf"}, 32'(no_buf), 32'(exp_nobuf));
  endtask

  task automatic arm_all_seq(input int bsz);
    for (int i = 0; i < NDESC; i++) arm(i, 1'b1, bsz, (i + 1) % NDESC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    seed_val = $urandom(32'd4242);
    rst_n = 1'b0; frm_done = 1'b0; poll_demand = 1'b0;
    frm_len = '0; frm_match = '0; frm_err = '0;
    exp_pos = 0; exp_nobuf = 1'b0;
    for (int k = 0; k < 4*NDESC; k++) begin dmem[k] = '0; em[k] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check(ring_pos === '0, "R11 ring_pos", 32'(ring_pos), 0);
    check(no_buf === 1'b0 && busy === 1'b0, "R11 flags", {30'd0, no_buf, busy}, 0);
    check(dsc_rd_en === 1'b0 && dsc_wr_en === 1'b0, "R11 ports", {30'd0, dsc_rd_en, dsc_wr_en}, 0);

    // R3 R4 R5: single-buffer frame, station match
    arm_all_seq(256);
    send(64, 1, 0);
    check_ring("R3 R4 R5 single buffer");
    check(dmem[0] === 32'h0040_1C00, "R5 first+last word", dmem[0], 32'h0040_1C00);

    // R6: every error flag, multicast
    send(100, 3, 5'h1f);
    check_ring("R6 all errors");
    check(dmem[4][7:2] === 6'h3f, "R6 summary", 32'(dmem[4][7:2]), 32'h3f);

    // R5: length equal to buffer size stays in one descriptor
    send(256, 2, 5'h02);
    check_ring("R5 exact fit");

    // R7 R8: one byte over the buffer spills into the wrapped entry
    arm_all_seq(256);
    send(257, 1, 0);
    check_ring("R7 R8 spill with wrap");
    check(dmem[12] === 32'h0000_0800, "R8 first part bare", dmem[12], 32'h0000_0800);

    // R1: current descriptor not owned
    arm(1, 1'b0, 256, 2);
    send(80, 1, 0);
    check_ring("R1 unowned drop");

    // R9: frame during suspension is dropped, then poll resumes
    arm(1, 1'b1, 256, 2);
    send(90, 2, 0);
    check_ring("R9 suspended drop");
    poll();
    check_ring("R9 poll clears");
    send(90, 2, 0);
    check_ring("R9 resumed frame");

    // R10: second pulse while busy is ignored
    arm_all_seq(512);
    @(negedge clk);
    frm_done = 1'b1; frm_len = 12'd40; frm_match = 2'd1; frm_err = 5'd0;
    @(negedge clk);
    frm_done = 1'b0;
    model_frame(40, 1, 0);
    @(negedge clk);
    frm_done = 1'b1; frm_len = 12'd77; frm_match = 2'd3; frm_err = 5'd1;
    @(negedge clk);
    frm_done = 1'b0;
    wait_idle();
    check_ring("R10 ignored while busy");

    // Random phase: pointers run backwards around the ring (R7)
    for (int it = 0; it < 60; it++) begin
      int len, m, e;
      for (int i = 0; i < NDESC; i++)
        if (($urandom % 4) != 0) arm(i, 1'b1, 16 + int'($urandom % 112), (i + NDESC - 1) % NDESC);
      if (exp_nobuf && ($urandom % 2) == 0) poll();
      len = 1 + int'($urandom % 400);
      m   = int'($urandom % 4);
      e   = (($urandom % 3) == 0) ? int'($urandom % 32) : 0;
      send(len, m, e);
      check_ring("R7 R8 random frame");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule